// File: doc/BRIEF.md
# Alternating Two-Descriptor Receive DMA Channel

This block moves received Ethernet frames from a byte stream into a ring of fixed-size slots in memory. Software programs two descriptor sets. Each set has a base address, a count of free slots and a command register. A frame is stored in the next free slot of the active set. The frame data starts 16 bytes into the slot. A header holding the stored length, a status word and two counters supplied by the MAC is written at the slot base once the frame has ended.

Every completed frame decrements the remaining-slot count of its set and flags a completion that software acknowledges. When a set has used its last slot, it disarms itself and the channel moves to the other set. Software meanwhile reloads the exhausted set, so reception never waits for a refill. A control register holds the channel while sets are reloaded. A sticky error bit records frames that found no armed set.

The MAC side must leave at least one idle cycle after each end-of-frame byte. A byte that arrives in that cycle is discarded. The memory port writes one aligned 16-byte word per cycle.

Top module: `rxdma_pingpong`

## Requirements
- R1: After reset both sets are disarmed with base 0 and count 0, no completion or error is flagged, the active set is 0, `irq` is low and no memory write is issued.
- R2: Register map on word-aligned addresses. Set s (address bit 4 = s) has its command register at 0x10*s+0x0, its base at +0x4 and its remaining count at +0x8. A command read gives the armed flag in bit 15 and the done flag in bit 8. Writing 0x9800 arms the set, writing 0x1100 stops it, and any other command value has no effect on the armed flag.
- R3: A frame accepted by set s goes to slot address base + (SLOTS - count)*2048. Data byte k is written at slot + 16 + 16*(k/16), in bits 8*(k%16) of a 128-bit word. The final partial word is zero-filled. A word's write appears on the port the cycle after its last byte.
- R4: Two cycles after the end-of-frame byte, the header word is written at the slot address. Bits [15:0] hold the stored length. Bits [31:16] hold the status: bit 8 is the truncation flag and bits 7:0 are `in_flags`. Bits [47:32] hold `in_runt` and bits [63:48] hold `in_coll`, both zero-extended. Bits [127:64] are zero.
- R5: Each completed frame decrements its set's count by one, sets that set's done flag and raises `irq`.
- R6: Writing 0x0100 to a command register clears that set's done flag. `irq` is the OR of both done flags and the error flag.
- R7: When a frame uses the last slot of a set, that set disarms and the active set (status bit 4) switches to the other set.
- R8: If the active set is not usable (disarmed or count 0) but the other one is, the next frame is placed in the other set, and that set becomes active.
- R9: A frame that starts while neither set is usable is dropped with no memory write and sets the error flag (status bit 13). Only the hold command clears it.
- R10: Writing 0x8800 to the control register at 0x20 sets hold (status bit 15), clears both done flags and the error flag, and makes set 0 active. While hold is set, frames are dropped without any write or error. Writing 0x0400 releases hold.
- R11: Frame bytes beyond 2032 are discarded. The header then reports length 2032 with status bit 8 set.
- R12: If a frame completes in the same cycle as an acknowledge to its set, the done flag stays set. A count written in the same cycle as a decrement takes the written value.
- R13: A count written above SLOTS is stored as SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_flags | input | 8 | MAC receive status, sampled with the last byte |
| in_runt | input | 8 | MAC runt counter, sampled with the last byte |
| in_coll | input | 8 | MAC collision counter, sampled with the last byte |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Byte address of the 16-byte word |
| mem_wdata | output | 128 | Memory word data |
| irq | output | 1 | Completion or error interrupt |

## Verification
Two pairs of events can land in the same clock edge. In the first pair, a one-byte frame completes into a set in the same cycle that software acknowledges that set. In the second, the same frame decrements the count in the cycle that software writes a new count. The bench starts the frame and the register write together, so both reach the design on the same edge. It then reads back the command and count registers. The done flag must still be set, and the count must equal the written value, not that value minus one.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    localparam int HDR_BYTES  = 16;
    localparam int WORD_BYTES = 16;
    localparam int WORD_W     = WORD_BYTES * 8;

    localparam logic [15:0] CMD_ARM  = 16'h9800;
    localparam logic [15:0] CMD_STOP = 16'h1100;
    localparam logic [15:0] CMD_ACK  = 16'h0100;
    localparam logic [15:0] CTL_HOLD = 16'h8800;
    localparam logic [15:0] CTL_RUN  = 16'h0400;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_RECV = 2'd1,
        W_DROP = 2'd2,
        W_HDR  = 2'd3
    } wstate_e;
endpackage

// File: rtl/rxdma_set.sv
module rxdma_set #(
    parameter int SET_IDX = 0,
    parameter int SLOTS   = 8,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [5:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             consume,
    input  logic             clr_done,
    output logic             armed,
    output logic             done,
    output logic [31:0]      base,
    output logic [CNT_W-1:0] cnt
);
    import rxdma_pkg::*;

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

    typedef struct packed {
        logic             armed;
        logic             done;
        logic [31:0]      base;
        logic [CNT_W-1:0] cnt;
    } set_s;

    set_s q, d;
    logic hit, hit_cmd, hit_base, hit_cnt;

    always_comb begin
        hit      = reg_wr && !reg_addr[5] && (reg_addr[4] == SET_IDX[0]) && (reg_addr[1:0] == 2'b00);
        hit_cmd  = hit && (reg_addr[3:2] == 2'd0);
        hit_base = hit && (reg_addr[3:2] == 2'd1);
        hit_cnt  = hit && (reg_addr[3:2] == 2'd2);

        d = q;
        if (clr_done) begin
            d.done = 1'b0;
        end
        if (consume) begin
            d.done = 1'b1;
            if (q.cnt != '0) begin
                d.cnt = q.cnt - ONE;
            end
            if (q.cnt == ONE) begin
                d.armed = 1'b0;
            end
        end
        if (hit_cmd) begin
            case (reg_wdata[15:0])
                CMD_ARM:  d.armed = 1'b1;
                CMD_STOP: d.armed = 1'b0;
                CMD_ACK:  if (!consume) d.done = 1'b0;
                default:  ;
            endcase
        end
        if (hit_base) begin
            d.base = reg_wdata;
        end
        if (hit_cnt) begin
            d.cnt = (reg_wdata > 32'(SLOTS)) ? FULL : reg_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign armed = q.armed;
    assign done  = q.done;
    assign base  = q.base;
    assign cnt   = q.cnt;
endmodule

// File: rtl/rxdma_writer.sv
module rxdma_writer #(
    parameter int SLOTS      = 8,
    parameter int SLOT_BYTES = 2048,
    parameter int CNT_W      = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [7:0]                  in_data,
    input  logic                        in_last,
    input  logic [7:0]                  in_flags,
    input  logic [7:0]                  in_runt,
    input  logic [7:0]                  in_coll,
    input  logic                        hold,
    input  logic                        clr,
    input  logic [1:0]                  armed,
    input  logic [1:0][CNT_W-1:0]       set_cnt,
    input  logic [1:0][31:0]            set_base,
    output logic [1:0]                  consume,
    output logic                        ovf,
    output logic                        active,
    output logic                        mem_we,
    output logic [31:0]                 mem_addr,
    output logic [rxdma_pkg::WORD_W-1:0] mem_wdata
);
    import rxdma_pkg::*;

    localparam int SLOT_SH = $clog2(SLOT_BYTES);
    localparam logic [15:0] CAP16 = 16'(SLOT_BYTES - HDR_BYTES);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        wstate_e           st;
        logic              act;
        logic              ovf;
        logic              fset;
        logic [31:0]       slot_addr;
        logic [15:0]       bcnt;
        logic [3:0]        fill;
        logic [WORD_W-1:0] buf_w;
        logic              trunc;
        logic [7:0]        flags;
        logic [7:0]        runt;
        logic [7:0]        coll;
        logic              we;
        logic [31:0]       addr;
        logic [WORD_W-1:0] wdata;
    } wr_s;

    wr_s q, d;
    logic [1:0]        usable;
    logic              sel, start_ok, take;
    logic [31:0]       slot_off;
    logic              cur_set;
    logic [31:0]       cur_slot;
    logic [15:0]       cur_bcnt;
    logic [3:0]        cur_fill;
    logic [WORD_W-1:0] cur_buf, nbuf;

    always_comb begin
        d       = q;
        d.we    = 1'b0;
        consume = '0;
        for (int i = 0; i < 2; i++) begin
            usable[i] = armed[i] && (set_cnt[i] != '0);
        end
        sel      = usable[q.act] ? q.act : ~q.act;
        start_ok = usable[q.act] || usable[~q.act];
        slot_off = (32'(SLOTS) - 32'(set_cnt[sel])) << SLOT_SH;
        take     = 1'b0;
        cur_set  = q.fset;
        cur_slot = q.slot_addr;
        cur_bcnt = q.bcnt;
        cur_fill = q.fill;
        cur_buf  = q.buf_w;
        nbuf     = q.buf_w;

        case (q.st)
            W_IDLE: begin
                if (in_valid) begin
                    if (hold) begin
                        if (!in_last) d.st = W_DROP;
                    end else if (start_ok) begin
                        d.act       = sel;
                        d.fset      = sel;
                        cur_set     = sel;
                        cur_slot    = set_base[sel] + slot_off;
                        d.slot_addr = cur_slot;
                        cur_bcnt    = '0;
                        cur_fill    = '0;
                        cur_buf     = '0;
                        d.trunc     = 1'b0;
                        take        = 1'b1;
                        d.st        = W_RECV;
                    end else begin
                        d.ovf = 1'b1;
                        if (!in_last) d.st = W_DROP;
                    end
                end
            end
            W_RECV: begin
                if (in_valid) take = 1'b1;
            end
            W_DROP: begin
                if (in_valid && in_last) d.st = W_IDLE;
            end
            W_HDR: begin
                d.we    = 1'b1;
                d.addr  = q.slot_addr;
                d.wdata = {64'b0, 8'b0, q.coll, 8'b0, q.runt, 7'b0, q.trunc, q.flags, q.bcnt};
                d.st    = W_IDLE;
            end
            default: d.st = W_IDLE;
        endcase

        if (take) begin
            if (cur_bcnt == CAP16) begin
                d.trunc = 1'b1;
            end else begin
                nbuf = cur_buf;
                nbuf[{cur_fill, 3'b000} +: 8] = in_data;
                if ((cur_fill == 4'hF) || in_last) begin
                    d.we    = 1'b1;
                    d.addr  = cur_slot + 32'(HDR_BYTES) + 32'({cur_bcnt[15:4], 4'b0000});
                    d.wdata = nbuf;
                    d.buf_w = '0;
                    d.fill  = '0;
                end else begin
                    d.buf_w = nbuf;
                    d.fill  = cur_fill + 4'd1;
                end
                d.bcnt = cur_bcnt + 16'd1;
            end
            if (in_last) begin
                d.st             = W_HDR;
                consume[cur_set] = 1'b1;
                if (set_cnt[cur_set] == ONE) d.act = ~cur_set;
                d.flags = in_flags;
                d.runt  = in_runt;
                d.coll  = in_coll;
            end
        end

        if (clr) begin
            d.ovf = 1'b0;
            d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ovf       = q.ovf;
    assign active    = q.act;
    assign mem_we    = q.we;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
endmodule

// File: rtl/rxdma_pingpong.sv
module rxdma_pingpong #(
    parameter int SLOTS      = 8,
    parameter int SLOT_BYTES = 2048
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [5:0]   reg_addr,
    input  logic [31:0]  reg_wdata,
    output logic [31:0]  reg_rdata,
    input  logic         in_valid,
    input  logic [7:0]   in_data,
    input  logic         in_last,
    input  logic [7:0]   in_flags,
    input  logic [7:0]   in_runt,
    input  logic [7:0]   in_coll,
    output logic         mem_we,
    output logic [31:0]  mem_addr,
    output logic [127:0] mem_wdata,
    output logic         irq
);
    import rxdma_pkg::*;

    localparam int CNT_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic hold;
    } ctl_s;

    ctl_s                 q, d;
    logic                 ctl_hit, hold_pulse;
    logic [1:0]           armed, done, consume;
    logic [1:0][31:0]     set_base;
    logic [1:0][CNT_W-1:0] set_cnt;
    logic                 ovf, active;

    always_comb begin
        ctl_hit    = reg_wr && (reg_addr == 6'h20);
        hold_pulse = ctl_hit && (reg_wdata[15:0] == CTL_HOLD);
        d = q;
        if (hold_pulse) begin
            d.hold = 1'b1;
        end else if (ctl_hit && (reg_wdata[15:0] == CTL_RUN)) begin
            d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < 2; g++) begin : g_set
        rxdma_set #(
            .SET_IDX (g),
            .SLOTS   (SLOTS),
            .CNT_W   (CNT_W)
        ) u_set (
            .clk       (clk),
            .rst_n     (rst_n),
            .reg_wr    (reg_wr),
            .reg_addr  (reg_addr),
            .reg_wdata (reg_wdata),
            .consume   (consume[g]),
            .clr_done  (hold_pulse),
            .armed     (armed[g]),
            .done      (done[g]),
            .base      (set_base[g]),
            .cnt       (set_cnt[g])
        );
    end

    rxdma_writer #(
        .SLOTS      (SLOTS),
        .SLOT_BYTES (SLOT_BYTES),
        .CNT_W      (CNT_W)
    ) u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_flags  (in_flags),
        .in_runt   (in_runt),
        .in_coll   (in_coll),
        .hold      (q.hold),
        .clr       (hold_pulse),
        .armed     (armed),
        .set_cnt   (set_cnt),
        .set_base  (set_base),
        .consume   (consume),
        .ovf       (ovf),
        .active    (active),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == 6'h20) begin
            reg_rdata[15] = q.hold;
            reg_rdata[13] = ovf;
            reg_rdata[8]  = |done;
            reg_rdata[4]  = active;
        end else if (!reg_addr[5] && (reg_addr[1:0] == 2'b00)) begin
            case (reg_addr[3:2])
                2'd0: begin
                    reg_rdata[15] = armed[reg_addr[4]];
                    reg_rdata[8]  = done[reg_addr[4]];
                end
                2'd1:    reg_rdata = set_base[reg_addr[4]];
                2'd2:    reg_rdata = 32'(set_cnt[reg_addr[4]]);
                default: reg_rdata = '0;
            endcase
        end
    end

    assign irq = (|done) | ovf;
endmodule

// File: rtl/rxdma_chk.sv
module rxdma_chk #(
    parameter int SLOTS = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [5:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic             irq,
    input logic             ovf,
    input logic [CNT_W-1:0] cnt0
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

    // R3
    mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[3:0] == 4'h0));

    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr));

    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf) |-> $past(reg_wr && (reg_addr == 6'h20) && (reg_wdata[15:0] == 16'h8800)));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr) |-> ((cnt0 == $past(cnt0)) || ((cnt0 + ONE) == $past(cnt0))));

    // R13
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt0 <= FULL);
endmodule

bind rxdma_pingpong rxdma_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .irq       (irq),
    .ovf       (ovf),
    .cnt0      (set_cnt[0])
);

// File: tb/tb_rxdma_pingpong.sv
`timescale 1ns/1ps
module tb_rxdma_pingpong;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [5:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         in_valid = 1'b0;
    logic [7:0]   in_data = '0;
    logic         in_last = 1'b0;
    logic [7:0]   in_flags = '0;
    logic [7:0]   in_runt = '0;
    logic [7:0]   in_coll = '0;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         irq;

    always #4 clk = ~clk;

    rxdma_pingpong dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_flags(in_flags),
        .in_runt(in_runt), .in_coll(in_coll), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_armed[2];
    int m_done[2];
    int m_cnt[2];
    logic [31:0] m_base[2];
    int m_act = 0;
    int m_ovf = 0;
    int m_hold = 0;
    logic [159:0] exp_q[$];

    task automatic chk(string req, string what, logic [159:0] act, logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            logic [159:0] e;
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R3 unexpected write actual %0h expected none", mem_addr);
            end else begin
                e = exp_q.pop_front();
                chk("R3/R4", "memory write", {mem_addr, mem_wdata}, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    task automatic model_wr(logic [5:0] a, logic [31:0] v);
        int s;
        if (a == 6'h20) begin
            if (v[15:0] == 16'h8800) begin
                m_hold = 1; m_ovf = 0; m_done[0] = 0; m_done[1] = 0; m_act = 0;
            end else if (v[15:0] == 16'h0400) begin
                m_hold = 0;
            end
        end else if (!a[5] && a[1:0] == 2'b00) begin
            s = int'(a[4]);
            case (a[3:2])
                2'd0: begin
                    if (v[15:0] == 16'h9800) m_armed[s] = 1;
                    else if (v[15:0] == 16'h1100) m_armed[s] = 0;
                    else if (v[15:0] == 16'h0100) m_done[s] = 0;
                end
                2'd1: m_base[s] = v;
                2'd2: m_cnt[s] = (v > 8) ? 8 : int'(v);
                default: ;
            endcase
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        model_wr(a, v);
    endtask

    task automatic rd_chk(string req, string what, logic [5:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, what, 160'(reg_rdata), 160'(exp));
    endtask

    function automatic bit usable(int s);
        return (m_armed[s] != 0) && (m_cnt[s] > 0);
    endfunction

    task automatic send_frame(int len, int seed, logic [7:0] fl, logic [7:0] ru, logic [7:0] co);
        int sel = -1;
        int stored;
        logic [31:0] slot;
        logic [127:0] w;
        if (m_hold == 0) begin
            if (usable(m_act)) sel = m_act;
            else if (usable(1 - m_act)) sel = 1 - m_act;
            else m_ovf = 1;
        end
        if (sel >= 0) begin
            m_act = sel;
            slot = m_base[sel] + 32'((8 - m_cnt[sel]) * 2048);
            stored = (len > 2032) ? 2032 : len;
            w = '0;
            for (int k = 0; k < stored; k++) begin
                w[(k % 16) * 8 +: 8] = 8'((seed + k) & 255);
                if ((k % 16 == 15) || (k == stored - 1)) begin
                    exp_q.push_back({slot + 32'(16 + (k / 16) * 16), w});
                    w = '0;
                end
            end
            exp_q.push_back({slot, 64'b0, 8'b0, co, 8'b0, ru, 7'b0, (len > 2032) ? 1'b1 : 1'b0, fl, 16'(stored)});
            m_cnt[sel] = m_cnt[sel] - 1;
            m_done[sel] = 1;
            if (m_cnt[sel] == 0) begin
                m_armed[sel] = 0;
                m_act = 1 - sel;
            end
        end
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'((seed + k) & 255);
            in_last  = (k == len - 1);
            in_flags = fl; in_runt = ru; in_coll = co;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(string req);
        rd_chk(req, "cmd0", 6'h00, 32'((m_armed[0] << 15) | (m_done[0] << 8)));
        rd_chk(req, "cmd1", 6'h10, 32'((m_armed[1] << 15) | (m_done[1] << 8)));
        rd_chk(req, "cnt0", 6'h08, 32'(m_cnt[0]));
        rd_chk(req, "cnt1", 6'h18, 32'(m_cnt[1]));
        rd_chk(req, "status", 6'h20, 32'((m_hold << 15) | (m_ovf << 13) |
               (((m_done[0] | m_done[1]) != 0 ? 1 : 0) << 8) | (m_act << 4)));
        chk(req, "irq", 160'(irq), 160'((m_done[0] | m_done[1] | m_ovf) != 0));
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_armed[i] = 0; m_done[i] = 0; m_cnt[i] = 0; m_base[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1");
        rd_chk("R1", "base0", 6'h04, 32'h0);

        // R2: program both sets, read back, ignored command value
        wr(6'h04, 32'h0001_0000);
        wr(6'h08, 32'd2);
        wr(6'h14, 32'h0004_0000);
        wr(6'h18, 32'd3);
        wr(6'h00, 32'h1234);
        check_all("R2");
        wr(6'h00, 32'h9800);
        wr(6'h10, 32'h9800);
        rd_chk("R2", "base0", 6'h04, 32'h0001_0000);
        rd_chk("R2", "base1", 6'h14, 32'h0004_0000);
        check_all("R2");

        // R3 R4 R5: first frame into set 0 slot 0
        send_frame(20, 5, 8'hA5, 8'h03, 8'h07);
        check_all("R5");

        // R6: acknowledge clears done and irq
        wr(6'h00, 32'h0100);
        check_all("R6");

        // R7: last slot of set 0, switch to set 1
        send_frame(33, 40, 8'h11, 8'h00, 8'h01);
        check_all("R7");
        send_frame(16, 90, 8'h22, 8'h05, 8'h00);
        check_all("R7");
        wr(6'h00, 32'h0100);
        wr(6'h10, 32'h0100);

        // R9: no usable set drops and flags error
        wr(6'h10, 32'h1100);
        send_frame(10, 3, 8'h00, 8'h00, 8'h00);
        check_all("R9");
        wr(6'h00, 32'h0100);
        check_all("R9");

        // R10: hold clears error and drops frames
        wr(6'h20, 32'h8800);
        check_all("R10");
        wr(6'h08, 32'd4);
        wr(6'h00, 32'h9800);
        send_frame(8, 1, 8'h00, 8'h00, 8'h00);
        check_all("R10");
        wr(6'h20, 32'h0400);
        check_all("R10");

        // R8: active set stopped, other set takes the frame
        wr(6'h18, 32'd2);
        wr(6'h10, 32'h9800);
        wr(6'h00, 32'h1100);
        send_frame(5, 77, 8'h33, 8'h01, 8'h02);
        check_all("R8");

        // R11: truncation in set 1 last slot
        send_frame(2040, 9, 8'h44, 8'h00, 8'h00);
        check_all("R11");
        wr(6'h10, 32'h0100);

        // R12: completion and acknowledge on the same edge
        wr(6'h00, 32'h9800);
        fork
            send_frame(1, 200, 8'h55, 8'h00, 8'h00);
            wr(6'h00, 32'h0100);
        join
        m_done[0] = 1;
        check_all("R12");

        // R12: count write and decrement on the same edge
        fork
            send_frame(1, 201, 8'h66, 8'h00, 8'h00);
            wr(6'h08, 32'd5);
        join
        m_cnt[0] = 5;
        check_all("R12");

        // R13: saturating count write
        wr(6'h18, 32'd15);
        check_all("R13");

        repeat (4) @(negedge clk);
        chk("R3", "pending writes", 160'(exp_q.size()), 160'(0));
        finish_run();
    end
endmodule